// File: doc/BRIEF.md
# Pointer Addressing Mode Generator

This block takes a pointer register value, a displacement and an access size, and works out where a load or store goes and what the pointer holds afterwards. Seven behaviours are selected by a 3-bit mode code:

- plain indirect;
- an offset that is added or subtracted only for this access;
- modify-before-access, upward or downward;
- modify-after-access, upward or downward.

The displacement can be a full register value or a small unsigned constant. It is a count of elements, so it is scaled by the element size before any arithmetic. All address arithmetic wraps modulo 2^ADDR_W.

Each request is presented with `req_valid`. One clock later the block shows the result registers:

- the effective address;
- the pointer value to write back;
- a write-back enable.

The register file and the memory port that use these results sit outside the block.

Top module: `ptr_agu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `res_wb`, `res_addr` and `res_ptr` all become zero.
- R2: Results appear exactly one clock after the request. `res_valid` is high in the cycle after `req_valid` was high and low otherwise. `res_wb` is never high when `res_valid` is low.
- R3: Mode 0 (indirect) and the reserved mode 7 give `res_addr` = base and `res_ptr` = base, with `res_wb` = 0.
- R4: Mode 1 (offset up) and mode 2 (offset down) give `res_addr` = base + d or base − d respectively. `res_ptr` stays equal to base and `res_wb` = 0.
- R5: Mode 3 (pre-increment) and mode 4 (pre-decrement) compute base ± d and use it both as `res_addr` and as `res_ptr`, with `res_wb` = 1.
- R6: Mode 5 (post-increment) and mode 6 (post-decrement) give `res_addr` = base and `res_ptr` = base ± d, with `res_wb` = 1.
- R7: The displacement d is the raw element count times 1, 2, 4 or 8 bytes, for `req_size` codes 0, 1, 2 and 3 respectively.
- R8: With `req_dsrc` = 0 the raw count is the 5-bit `req_dconst`, zero-extended. With `req_dsrc` = 1 it is the full `req_dreg` value, and the unselected source has no effect.
- R9: With `req_dnone` = 1 both displacement inputs are ignored. The raw count is 1 in modes 3 to 6 and 0 in modes 1 and 2.
- R10: Every sum and difference wraps modulo 2^32: no carry or borrow leaves the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_size | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_dsrc | input | 1 | Displacement source: 0 constant, 1 register |
| req_dnone | input | 1 | No displacement given |
| req_dconst | input | 5 | Unsigned constant element count |
| req_dreg | input | 32 | Register element count |
| req_base | input | 32 | Current pointer value |
| res_valid | output | 1 | Result registers hold a new result |
| res_addr | output | 32 | Effective address for the access |
| res_ptr | output | 32 | Pointer value after the access |
| res_wb | output | 1 | Pointer write-back enable |

## Verification
The effective address and the updated pointer are formed in the same cycle from one adder result. In the post-modify modes they take different values, and in the pre-modify modes they take the same value. The bench provokes this overlap by issuing back-to-back post-increment, pre-decrement and offset requests on a single pointer, including bases close enough to 0 and to 2^32 that the shared sum wraps. For every request the scoreboard judges the address and the new pointer independently. A design that feeds the wrong one of the two values to either output is caught even when the write-back enable is correct.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [2:0] {
    AM_INDIRECT = 3'd0,
    AM_OFS_UP   = 3'd1,
    AM_OFS_DN   = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4,
    AM_POST_INC = 3'd5,
    AM_POST_DEC = 3'd6,
    AM_RSVD     = 3'd7
  } amode_e;

  typedef struct packed {
    logic subtract;   // apply base - d instead of base + d
    logic addr_sum;   // address taken from the adder result
    logic writeback;  // pointer is updated
    logic modify;     // increment/decrement family (default count 1)
  } mode_ctl_t;

endpackage

// File: rtl/ptr_mode_dec.sv
module ptr_mode_dec
  import ptr_agu_pkg::*;
(
  input  logic [2:0] mode,
  output mode_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    unique case (amode_e'(mode))
      AM_OFS_UP:   begin ctl.addr_sum = 1'b1; end
      AM_OFS_DN:   begin ctl.addr_sum = 1'b1; ctl.subtract = 1'b1; end
      AM_PRE_INC:  begin ctl.addr_sum = 1'b1; ctl.writeback = 1'b1; ctl.modify = 1'b1; end
      AM_PRE_DEC:  begin ctl.addr_sum = 1'b1; ctl.writeback = 1'b1; ctl.modify = 1'b1;
                         ctl.subtract = 1'b1; end
      AM_POST_INC: begin ctl.writeback = 1'b1; ctl.modify = 1'b1; end
      AM_POST_DEC: begin ctl.writeback = 1'b1; ctl.modify = 1'b1; ctl.subtract = 1'b1; end
      default:     begin ctl = '0; end
    endcase
  end

  // R6 R5: every pointer-updating mode belongs to the modify family
  always_comb begin
    a_r6_wb_implies_modify: assert (!ctl.writeback || ctl.modify);
  end

endmodule

// File: rtl/ptr_disp_scale.sv
module ptr_disp_scale #(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 5,
  parameter int SIZE_W  = 2
) (
  input  logic               use_reg,
  input  logic               none,
  input  logic               modify,
  input  logic [CONST_W-1:0] cval,
  input  logic [ADDR_W-1:0]  rval,
  input  logic [SIZE_W-1:0]  size,
  output logic [ADDR_W-1:0]  scaled
);

  localparam int NSIZE = 1 << SIZE_W;

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] cand [NSIZE];

  always_comb begin
    if (none)         raw = modify ? ADDR_W'(1) : '0;
    else if (use_reg) raw = rval;
    else              raw = ADDR_W'(cval);
  end

  for (genvar s = 0; s < NSIZE; s++) begin : g_scale
    assign cand[s] = raw << s;
  end

  assign scaled = cand[size];

  // R7: a scaled displacement is a whole number of elements
  always_comb begin
    a_r7_scale_aligned: assert (((scaled >> size) << size) == scaled);
  end

endmodule

// File: rtl/ptr_addsub.sv
module ptr_addsub #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] delta,
  input  logic              subtract,
  output logic [ADDR_W-1:0] result
);

  // R10: width-limited arithmetic, wraps modulo 2^ADDR_W
  always_comb begin
    if (subtract) result = base - delta;
    else          result = base + delta;
  end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 5,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_mode,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic               req_dsrc,
  input  logic               req_dnone,
  input  logic [CONST_W-1:0] req_dconst,
  input  logic [ADDR_W-1:0]  req_dreg,
  input  logic [ADDR_W-1:0]  req_base,
  output logic               res_valid,
  output logic [ADDR_W-1:0]  res_addr,
  output logic [ADDR_W-1:0]  res_ptr,
  output logic               res_wb
);

  mode_ctl_t         ctl;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] nxt_ptr;

  ptr_mode_dec u_dec (
    .mode (req_mode),
    .ctl  (ctl)
  );

  ptr_disp_scale #(
    .ADDR_W  (ADDR_W),
    .CONST_W (CONST_W),
    .SIZE_W  (SIZE_W)
  ) u_scale (
    .use_reg (req_dsrc),
    .none    (req_dnone),
    .modify  (ctl.modify),
    .cval    (req_dconst),
    .rval    (req_dreg),
    .size    (req_size),
    .scaled  (disp)
  );

  ptr_addsub #(.ADDR_W(ADDR_W)) u_add (
    .base     (req_base),
    .delta    (disp),
    .subtract (ctl.subtract),
    .result   (sum)
  );

  assign eff_addr = ctl.addr_sum  ? sum : req_base;
  assign nxt_ptr  = ctl.writeback ? sum : req_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_wb    <= 1'b0;
      res_addr  <= '0;
      res_ptr   <= '0;
    end else begin
      res_valid <= req_valid;
      res_wb    <= req_valid & ctl.writeback;
      if (req_valid) begin
        res_addr <= eff_addr;
        res_ptr  <= nxt_ptr;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && !res_wb));
  a_r3_indirect_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_mode == 3'd0 || req_mode == 3'd7)) |=>
    (!res_wb && res_addr == $past(req_base) && res_ptr == $past(req_base)));
  a_r4_offset_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_mode == 3'd1 || req_mode == 3'd2)) |=>
    (!res_wb && res_ptr == $past(req_base)));
  a_r5_pre_same: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_mode == 3'd3 || req_mode == 3'd4)) |=>
    (res_wb && res_addr == res_ptr));
  a_r6_post_old_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_mode == 3'd5 || req_mode == 3'd6)) |=>
    (res_wb && res_addr == $past(req_base)));

endmodule

// File: tb/ptr_agu_bench.sv
`timescale 1ns/1ps
module ptr_agu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic        req_dsrc = 1'b0;
  logic        req_dnone = 1'b0;
  logic [4:0]  req_dconst = '0;
  logic [31:0] req_dreg = '0;
  logic [31:0] req_base = '0;
  logic        res_valid;
  logic [31:0] res_addr;
  logic [31:0] res_ptr;
  logic        res_wb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] ptr;
    logic        wb;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  ptr_agu u_ptr_agu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_dsrc(req_dsrc), .req_dnone(req_dnone),
    .req_dconst(req_dconst), .req_dreg(req_dreg), .req_base(req_base),
    .res_valid(res_valid), .res_addr(res_addr), .res_ptr(res_ptr), .res_wb(res_wb)
  );

  function automatic exp_t model(input logic [2:0] m, input logic [1:0] sz,
                                 input logic src, input logic none,
                                 input logic [4:0] c, input logic [31:0] r,
                                 input logic [31:0] b, input string tag);
    exp_t e;
    logic [31:0] cnt, d, up, dn;
    bit modfam;
    modfam = (m >= 3'd3 && m <= 3'd6);
    if (none)     cnt = modfam ? 32'd1 : 32'd0;
    else if (src) cnt = r;
    else          cnt = {27'd0, c};
    d  = cnt * (32'd1 << sz);
    up = b + d;
    dn = b - d;
    e.tag = tag;
    case (m)
      3'd1: begin e.addr = up; e.ptr = b;  e.wb = 1'b0; end
      3'd2: begin e.addr = dn; e.ptr = b;  e.wb = 1'b0; end
      3'd3: begin e.addr = up; e.ptr = up; e.wb = 1'b1; end
      3'd4: begin e.addr = dn; e.ptr = dn; e.wb = 1'b1; end
      3'd5: begin e.addr = b;  e.ptr = up; e.wb = 1'b1; end
      3'd6: begin e.addr = b;  e.ptr = dn; e.wb = 1'b1; end
      default: begin e.addr = b; e.ptr = b; e.wb = 1'b0; end
    endcase
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [2:0] m, input logic [1:0] sz,
                      input logic src, input logic none, input logic [4:0] c,
                      input logic [31:0] r, input logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_size = sz; req_dsrc = src;
    req_dnone = none; req_dconst = c; req_dreg = r; req_base = b;
    sb.push_back(model(m, sz, src, none, c, r, b, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: compare results against scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check("R2 unexpected result", 32'(res_valid), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " addr"}, res_addr, e.addr);
          check({e.tag, " ptr"},  res_ptr,  e.ptr);
          check({e.tag, " wb"},   32'(res_wb), 32'(e.wb));
        end
      end else if (res_wb) begin
        check("R2 wb without valid", 32'(res_wb), 32'd0);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 wb",    32'(res_wb),    32'd0);
    check("R1 addr",  res_addr,       32'd0);
    check("R1 ptr",   res_ptr,        32'd0);
    rst = 1'b0;
    idle(2);
    check("R2 idle valid", 32'(res_valid), 32'd0);

    send("R3 indirect",        3'd0, 2'd2, 1'b0, 1'b0, 5'd7, 32'd0, 32'h0000_1000);
    send("R3 reserved",        3'd7, 2'd3, 1'b1, 1'b0, 5'd0, 32'd9, 32'h0000_2000);
    send("R4 offset up",       3'd1, 2'd2, 1'b0, 1'b0, 5'd3, 32'd0, 32'h0000_1000);
    send("R4 offset down",     3'd2, 2'd1, 1'b1, 1'b0, 5'd0, 32'd5, 32'h0000_1000);
    send("R5 pre inc",         3'd3, 2'd3, 1'b0, 1'b0, 5'd2, 32'd0, 32'h0000_2000);
    send("R5 pre dec",         3'd4, 2'd2, 1'b0, 1'b0, 5'd31, 32'd0, 32'h0000_2000);
    send("R6 post inc",        3'd5, 2'd1, 1'b0, 1'b0, 5'd4, 32'd0, 32'h0000_3000);
    send("R6 post dec",        3'd6, 2'd0, 1'b0, 1'b0, 5'd9, 32'd0, 32'h0000_3000);
    for (int s = 0; s < 4; s++)
      send("R7 size scale",    3'd3, 2'(s), 1'b0, 1'b0, 5'd1, 32'd0, 32'h0000_4000);
    send("R8 reg source",      3'd1, 2'd2, 1'b1, 1'b0, 5'd31, 32'h100, 32'h0000_0000);
    send("R8 const source",    3'd1, 2'd0, 1'b0, 1'b0, 5'd31, 32'h1234, 32'h0000_0100);
    send("R9 default post",    3'd5, 2'd1, 1'b1, 1'b1, 5'd7, 32'd77, 32'h0000_5000);
    send("R9 default pre dec", 3'd4, 2'd3, 1'b0, 1'b1, 5'd7, 32'd77, 32'h0000_5000);
    send("R9 no offset",       3'd1, 2'd2, 1'b0, 1'b1, 5'd7, 32'd77, 32'h0000_5000);
    send("R10 wrap up",        3'd5, 2'd3, 1'b0, 1'b0, 5'd2, 32'd0, 32'hFFFF_FFF8);
    send("R10 wrap down",      3'd4, 2'd2, 1'b0, 1'b0, 5'd3, 32'd0, 32'h0000_0004);
    send("R10 wrap offset",    3'd2, 2'd0, 1'b1, 1'b0, 5'd0, 32'h10, 32'h0000_0008);
    idle(1);
    send("R2 after gap",       3'd6, 2'd2, 1'b1, 1'b0, 5'd0, 32'h4000_0000, 32'h0000_0010);
    for (int k = 0; k < 24; k++)
      send("R5 R6 stream", 3'(3 + (k % 4)), 2'(k % 4), 1'(k % 2), 1'(k % 5 == 0),
           5'(k * 7), 32'(k * 1013), 32'hFFFF_FF00 + 32'(k * 24));
    idle(3);
    check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule